// File: doc/BRIEF.md
# Root Hub Port Status Register

This block holds the 16-bit status and control word of each downstream port of a full/low-speed root hub. The default build has two ports. Software writes a word to a port through a narrow write interface, and reads any port through a combinational read multiplexer. The device side raises single-cycle attach, detach and remote-wakeup events for each port. On attach it also reports whether the device is low speed.

Each port is governed by a small state machine with three states:
- `PS_EMPTY`: no device on the port.
- `PS_PRESENT`: a device is attached.
- `PS_REAPPLY`: a one-cycle state entered after a controller reset while a device was attached.

Transitions:
- `EMPTY->PRESENT` on attach.
- `PRESENT->EMPTY` on detach.
- `PRESENT->REAPPLY` on controller reset.
- `REAPPLY->PRESENT` on the following cycle.
- `REAPPLY->EMPTY` if a detach arrives in that cycle.
- `EMPTY->EMPTY` on controller reset.

Writes merge the written word with the bits that software cannot change and with the change bits that a written 1 clears. A write that raises the port-reset bit while a device is attached produces a one-cycle bus-reset request towards that device.

Top module: `rh_port_regs`

## Requirements
- R1: After `rst_n` is released, every port word reads 0x0000 and `bus_reset_req` is all zero.
- R2: A write leaves the bits in mask 0x01BB unchanged, and every other bit takes the written value. Bit positions: connected 0, connect-changed 1, enabled 2, enable-changed 3, resume-seen 6, low-speed 8, port-reset 9, suspend 12.
- R3: Writing 1 to bit 1 or bit 3 clears that bit. Writing 0 to either leaves it unchanged.
- R4: A write that takes bit 9 from 0 to 1 on a port with an attached device drives that port's `bus_reset_req` high for exactly the one cycle after the write. There is no pulse if bit 9 was already 1 or if no device is attached.
- R5: An attach event sets bits 0 and 1. It sets bit 8 to the value of `dev_lowspeed`.
- R6: A detach event acts on two pairs of bits:
  - If bit 0 is set, it clears bit 0 and sets bit 1.
  - If bit 2 is set, it clears bit 2 and sets bit 3.
  - A detach on a port that is neither connected nor enabled changes nothing.
- R7: A wakeup event sets bit 6 only when bit 12 is set. Otherwise the word is unchanged.
- R8: `rd_data` shows the word of port `rd_port` in the same cycle. An index at or beyond `NUM_PORTS` reads 0xFF7F.
- R9: A controller reset (`hc_reset`) clears every port word to 0x0000 at the next edge. One cycle later, each port whose device is still attached gets the attach behaviour of R5 again, using the stored speed.
- R10: When a write and an attach, detach or wakeup event reach the same port in the same cycle, the event is applied on top of the merged write result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hc_reset | input | 1 | Controller/global reset pulse, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | IDX_W | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_port | input | IDX_W | Port index of the read |
| rd_data | output | 16 | Read data, combinational |
| dev_attach | input | NUM_PORTS | Attach event for each port |
| dev_detach | input | NUM_PORTS | Detach event for each port |
| dev_lowspeed | input | NUM_PORTS | Speed of the attaching device (1 = low) |
| dev_wakeup | input | NUM_PORTS | Remote-wakeup event for each port |
| bus_reset_req | output | NUM_PORTS | One-cycle reset request to the attached device |
| port_value | output | 16*NUM_PORTS | All port words, port 0 in the low bits |

## Verification
The hardest state to reach from the ports is `PS_REAPPLY`. It lasts one cycle, and it only shows a non-zero result if a device was attached before the controller reset. The bench attaches a low-speed device on one port and a full-speed device on the other before pulsing `hc_reset`. It then checks the zeroed words in the first cycle and the restored connect and speed bits in the second. The same-cycle collision of a write and an event is reached by driving both at one edge. In that test the write clears the connect-changed bit, and the attach must set it again.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int REG_W = 16;

    // bit positions of the port word
    localparam int PB_CONN    = 0;
    localparam int PB_CONN_CH = 1;
    localparam int PB_EN      = 2;
    localparam int PB_EN_CH   = 3;
    localparam int PB_RESUME  = 6;
    localparam int PB_LOWSPD  = 8;
    localparam int PB_PRST    = 9;
    localparam int PB_SUSP    = 12;

    localparam logic [REG_W-1:0] MASK_RO    = 16'h01BB;
    localparam logic [REG_W-1:0] MASK_W1C   = 16'h000A;
    localparam logic [REG_W-1:0] MASK_KEEP  = MASK_RO & ~MASK_W1C;
    localparam logic [REG_W-1:0] FILL_EMPTY = 16'hFF7F;

    typedef enum logic [1:0] {
        PS_EMPTY   = 2'd0,
        PS_PRESENT = 2'd1,
        PS_REAPPLY = 2'd2
    } pstate_t;

endpackage

// File: rtl/rh_port_slot.sv
module rh_port_slot
    import rh_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hc_reset,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ev_attach,
    input  logic             ev_detach,
    input  logic             ev_lowspeed,
    input  logic             ev_wakeup,
    output logic [REG_W-1:0] port_q,
    output logic             bus_reset_req
);

    pstate_t          st, st_nx;
    logic             ls_q;
    logic [REG_W-1:0] val_nx;
    logic             attach_now;
    logic             prst_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_EMPTY;
        else        st <= st_nx;
    end

    // next-state
    always_comb begin
        st_nx = st;
        if (hc_reset) begin
            st_nx = (st == PS_EMPTY) ? PS_EMPTY : PS_REAPPLY;
        end else begin
            unique case (st)
                PS_EMPTY:   if (ev_attach) st_nx = PS_PRESENT;
                PS_PRESENT: if (ev_detach) st_nx = PS_EMPTY;
                PS_REAPPLY: st_nx = ev_detach ? PS_EMPTY : PS_PRESENT;
                default:    st_nx = PS_EMPTY;
            endcase
        end
    end

    // merged next value of the port word
    always_comb begin
        val_nx = port_q;
        if (wr_hit) begin
            val_nx = (port_q & MASK_RO) | (wr_data & ~MASK_RO);
            val_nx = val_nx & ~(wr_data & MASK_W1C);
        end
        attach_now = ev_attach || (st == PS_REAPPLY && !ev_detach);
        if (attach_now) begin
            val_nx[PB_CONN]    = 1'b1;
            val_nx[PB_CONN_CH] = 1'b1;
            val_nx[PB_LOWSPD]  = ev_attach ? ev_lowspeed : ls_q;
        end
        if (ev_detach) begin
            if (val_nx[PB_CONN]) begin
                val_nx[PB_CONN]    = 1'b0;
                val_nx[PB_CONN_CH] = 1'b1;
            end
            if (val_nx[PB_EN]) begin
                val_nx[PB_EN]    = 1'b0;
                val_nx[PB_EN_CH] = 1'b1;
            end
        end
        if (ev_wakeup && val_nx[PB_SUSP] && !val_nx[PB_RESUME])
            val_nx[PB_RESUME] = 1'b1;
    end

    assign prst_rise = wr_hit && wr_data[PB_PRST] && !port_q[PB_PRST] && (st != PS_EMPTY);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q        <= '0;
            bus_reset_req <= 1'b0;
            ls_q          <= 1'b0;
        end else if (hc_reset) begin
            port_q        <= '0;
            bus_reset_req <= 1'b0;
        end else begin
            port_q        <= val_nx;
            bus_reset_req <= prst_rise;
            if (ev_attach) ls_q <= ev_lowspeed;
        end
    end

    // R2: software cannot move the plain read-only bits
    a_r2_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !ev_attach && !ev_detach && !ev_wakeup && !hc_reset && st != PS_REAPPLY)
        |=> ((port_q & MASK_KEEP) == ($past(port_q) & MASK_KEEP)));

    // R4: request is a single cycle and follows a rise of the reset bit
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_req |=> !bus_reset_req);
    a_r4_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_req |-> (port_q[PB_PRST] && !$past(port_q[PB_PRST])));

    // R9: controller reset zeroes the word
    a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hc_reset |=> (port_q == '0));

    // R7: wakeup on a suspended port sets resume-seen
    a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wakeup && port_q[PB_SUSP] && !wr_hit && !hc_reset) |=> port_q[PB_RESUME]);

endmodule

// File: rtl/rh_port_readmux.sv
module rh_port_readmux
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_PORTS*REG_W-1:0] words,
    input  logic [IDX_W-1:0]           idx,
    output logic [REG_W-1:0]           data
);

    always_comb begin
        data = FILL_EMPTY;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (idx == IDX_W'(i)) data = words[i*REG_W +: REG_W];
        end
    end

endmodule

// File: rtl/rh_port_regs.sv
module rh_port_regs
    import rh_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hc_reset,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_port,
    input  logic [15:0]                wr_data,
    input  logic [IDX_W-1:0]           rd_port,
    output logic [15:0]                rd_data,
    input  logic [NUM_PORTS-1:0]       dev_attach,
    input  logic [NUM_PORTS-1:0]       dev_detach,
    input  logic [NUM_PORTS-1:0]       dev_lowspeed,
    input  logic [NUM_PORTS-1:0]       dev_wakeup,
    output logic [NUM_PORTS-1:0]       bus_reset_req,
    output logic [NUM_PORTS*16-1:0]    port_value
);

    localparam int WORDS_W = NUM_PORTS * REG_W;

    logic [NUM_PORTS-1:0] wr_hit;
    logic [WORDS_W-1:0]   words;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign wr_hit[g] = wr_en && (wr_port == IDX_W'(g));

        rh_port_slot u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .hc_reset      (hc_reset),
            .wr_hit        (wr_hit[g]),
            .wr_data       (wr_data),
            .ev_attach     (dev_attach[g]),
            .ev_detach     (dev_detach[g]),
            .ev_lowspeed   (dev_lowspeed[g]),
            .ev_wakeup     (dev_wakeup[g]),
            .port_q        (words[g*REG_W +: REG_W]),
            .bus_reset_req (bus_reset_req[g])
        );
    end

    rh_port_readmux #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_rmux (
        .words (words),
        .idx   (rd_port),
        .data  (rd_data)
    );

    assign port_value = words;

    // R8: indices past the last port read the fill pattern
    always_comb begin
        if (rst_n && (int'(rd_port) >= NUM_PORTS))
            a_r8_fill: assert (rd_data == FILL_EMPTY);
    end

endmodule

// File: tb/rh_port_regs_bench.sv
module rh_port_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hc_reset = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_port = '0;
    logic [15:0]   wr_data = '0;
    logic [IW-1:0] rd_port = '0;
    logic [15:0]   rd_data;
    logic [NP-1:0] dev_attach = '0;
    logic [NP-1:0] dev_detach = '0;
    logic [NP-1:0] dev_lowspeed = '0;
    logic [NP-1:0] dev_wakeup = '0;
    logic [NP-1:0] bus_reset_req;
    logic [NP*16-1:0] port_value;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rh_port_regs #(.NUM_PORTS(NP), .IDX_W(IW)) u_rh_port_regs (
        .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset),
        .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_port(rd_port), .rd_data(rd_data),
        .dev_attach(dev_attach), .dev_detach(dev_detach),
        .dev_lowspeed(dev_lowspeed), .dev_wakeup(dev_wakeup),
        .bus_reset_req(bus_reset_req), .port_value(port_value)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_port(input string req, input int p, input logic [15:0] exp);
        rd_port = IW'(p);
        #1;
        chk(req, rd_data, exp);
    endtask

    // drive a write at a negedge, let one posedge pass, back at the next negedge
    task automatic do_write(input int p, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_port = IW'(p); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_event(input int p, input bit att, input bit det, input bit ls, input bit wk);
        @(negedge clk);
        dev_attach[p] = att; dev_detach[p] = det; dev_lowspeed[p] = ls; dev_wakeup[p] = wk;
        @(negedge clk);
        dev_attach = '0; dev_detach = '0; dev_lowspeed = '0; dev_wakeup = '0;
    endtask

    task automatic t_reset_state;
        chk_port("R1 port0", 0, 16'h0000);
        chk_port("R1 port1", 1, 16'h0000);
        chk("R1 req", {14'd0, bus_reset_req}, 16'h0000);
        chk_port("R8 idx2", 2, 16'hFF7F);
        chk_port("R8 idx3", 3, 16'hFF7F);
    endtask

    task automatic t_attach;
        do_event(0, 1, 0, 1, 0);
        chk_port("R5 low-speed attach", 0, 16'h0103);
        do_event(1, 1, 0, 0, 0);
        chk_port("R5 full-speed attach", 1, 16'h0003);
        chk("R8 port_value", port_value[15:0], 16'h0103);
    endtask

    task automatic t_write_merge;
        do_write(0, 16'hFFFF);
        chk_port("R2 R3 write all ones", 0, 16'hFF45);
        chk("R4 pulse on rise", {14'd0, bus_reset_req}, 16'h0001);
        @(negedge clk);
        chk("R4 pulse one cycle", {14'd0, bus_reset_req}, 16'h0000);
        do_write(0, 16'hFFFF);
        chk("R4 no pulse when already set", {14'd0, bus_reset_req}, 16'h0000);
        chk_port("R2 repeat write", 0, 16'hFF45);
        do_write(0, 16'h0000);
        chk_port("R2 read-only bits kept", 0, 16'h0101);
    endtask

    task automatic t_detach_w1c;
        do_write(0, 16'h0004);
        chk_port("R2 enable written", 0, 16'h0105);
        do_event(0, 0, 1, 0, 0);
        chk_port("R6 detach connected+enabled", 0, 16'h010A);
        do_write(0, 16'h0002);
        chk_port("R3 clear connect-changed only", 0, 16'h0108);
        do_write(0, 16'h0008);
        chk_port("R3 clear enable-changed", 0, 16'h0100);
        do_event(0, 0, 1, 0, 0);
        chk_port("R6 detach on idle port", 0, 16'h0100);
    endtask

    task automatic t_reset_no_device;
        do_write(0, 16'h0200);
        chk("R4 no pulse without device", {14'd0, bus_reset_req}, 16'h0000);
        chk_port("R2 reset bit stored", 0, 16'h0300);
        do_write(0, 16'h0000);
        chk_port("R2 reset bit cleared", 0, 16'h0100);
    endtask

    task automatic t_wakeup;
        do_event(1, 0, 0, 0, 1);
        chk_port("R7 wakeup without suspend", 1, 16'h0003);
        do_write(1, 16'h1000);
        do_event(1, 0, 0, 0, 1);
        chk_port("R7 wakeup while suspended", 1, 16'h1043);
        do_write(1, 16'h1000);
        chk_port("R7 resume-seen writable", 1, 16'h1003);
    endtask

    task automatic t_collision;
        @(negedge clk);
        wr_en = 1'b1; wr_port = 1; wr_data = 16'h1002;
        dev_attach[1] = 1'b1; dev_lowspeed[1] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; dev_attach = '0;
        chk_port("R10 attach after write", 1, 16'h1003);
    endtask

    task automatic t_hc_reset;
        do_event(0, 1, 0, 1, 0);
        chk_port("R5 reattach low speed", 0, 16'h0103);
        @(negedge clk);
        hc_reset = 1'b1;
        @(negedge clk);
        hc_reset = 1'b0;
        chk_port("R9 port0 zeroed", 0, 16'h0000);
        chk_port("R9 port1 zeroed", 1, 16'h0000);
        @(negedge clk);
        chk_port("R9 port0 reapplied", 0, 16'h0103);
        chk_port("R9 port1 reapplied", 1, 16'h0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_attach();
        t_write_merge();
        t_detach_w1c();
        t_reset_no_device();
        t_wakeup();
        t_collision();
        t_hc_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule